// File: doc/BRIEF.md
# Priority Throttle Request Arbiter

This block combines several independent throttle request sources, such as a mild thermal event, a severe thermal event and an overcurrent alarm, into one final throttle setting. Each source holds a small settings bundle: a numeric priority, a CPU throttle depth in percent and a 2-bit GPU throttle level. Software loads a bundle by placing it on a shared write bus and pulsing the write-enable bit for that source.

On every clock the arbiter looks at the sources whose request line is high and whose priority is valid. It picks the one with the largest priority and registers that source's whole bundle onto the outputs. It also reports the index of the winning source and whether any throttle is in force. Downstream logic uses the depth and level to skip clock pulses. That downstream logic, temperature sensing and interrupt generation are not part of this block.

Top module: `thr_arbiter`

## Requirements
- R1: After reset every source has priority 0, depth 0 and level 0, and the outputs read depth 0, level 0, active low and winner 0.
- R2: A rising clock edge with cfg_we[i] high loads cfg_prio, cfg_level and the depth into source i. Sources whose write-enable bit is low keep their bundle.
- R3: A source may win only while its request bit is high and its stored priority lies between 1 and 100 inclusive. A priority of 0 or of 101 to 127 takes the source out of arbitration.
- R4: Among the eligible sources, the one with the numerically largest priority wins. Its depth and level are forwarded together on thr_cpu_depth and thr_gpu_level.
- R5: When eligible sources share the top priority, the one with the lowest index wins.
- R6: With no eligible source, the outputs are depth 0, level 0, winner 0 and thr_active low.
- R7: Outputs are registered. Request values present at a rising edge appear on the outputs just after that edge. A configuration write at one edge affects the outputs from the following edge.
- R8: A depth above 100 written to a source is stored as 100, so thr_cpu_depth never exceeds 100.
- R9: The GPU level is a 2-bit code forwarded unchanged: 0 none, 1 low (50%), 2 medium (75%), 3 high (85%).
- R10: thr_active is high exactly when some source was eligible at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | NUM_SRC | Per-source write enable for the settings bundle |
| cfg_prio | input | PRIO_W | Priority to write (valid 1..PRIO_MAX) |
| cfg_depth | input | DEPTH_W | CPU throttle depth in percent to write |
| cfg_level | input | LVL_W | GPU throttle level code to write |
| req | input | NUM_SRC | Throttle request line per source |
| thr_cpu_depth | output | DEPTH_W | Final CPU throttle depth in percent |
| thr_gpu_level | output | LVL_W | Final GPU throttle level code |
| thr_active | output | 1 | A throttle is in force |
| thr_winner | output | IDX_W | Index of the winning source |

## Verification
The assertions assume only that req and the configuration bus are clean, synchronous levels held steady around each rising edge. They also assume that the outputs are read after an edge and never in the same cycle as the request that causes them. They make no assumption about how software spreads priorities, so ties, priorities out of range and oversized depths are all legal inputs. The stimulus drives every input on the falling edge and deliberately includes these cases: a directed sweep over all request patterns, forced ties, priorities of 0 and 101, a depth of 120, and a long random phase that writes any 7-bit priority and depth.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;

   typedef enum logic [1:0] {
      GLVL_NONE = 2'd0,
      GLVL_LOW  = 2'd1,
      GLVL_MED  = 2'd2,
      GLVL_HIGH = 2'd3
   } gpu_level_e;

   localparam int unsigned DEF_PRIO_MAX  = 100;
   localparam int unsigned DEF_DEPTH_MAX = 100;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/thr_cfg_bank.sv
module thr_cfg_bank #(
   parameter int unsigned NUM_SRC   = 3,
   parameter int unsigned PRIO_W    = 7,
   parameter int unsigned DEPTH_W   = 7,
   parameter int unsigned LVL_W     = 2,
   parameter int unsigned DEPTH_MAX = 100
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_SRC-1:0]           we,
   input  logic [PRIO_W-1:0]            wr_prio,
   input  logic [DEPTH_W-1:0]           wr_depth,
   input  logic [LVL_W-1:0]             wr_level,
   output logic [NUM_SRC*PRIO_W-1:0]    prio_flat,
   output logic [NUM_SRC*DEPTH_W-1:0]   depth_flat,
   output logic [NUM_SRC*LVL_W-1:0]     level_flat
);

   localparam logic [DEPTH_W-1:0] DEPTH_CAP = DEPTH_W'(DEPTH_MAX);

   logic [DEPTH_W-1:0] depth_sat;

   always_comb begin
      depth_sat = (wr_depth > DEPTH_CAP) ? DEPTH_CAP : wr_depth;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [PRIO_W-1:0]  prio_q;
      logic [DEPTH_W-1:0] depth_q;
      logic [LVL_W-1:0]   level_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            prio_q  <= '0;
            depth_q <= '0;
            level_q <= '0;
         end else if (we[s]) begin
            prio_q  <= wr_prio;
            depth_q <= depth_sat;
            level_q <= wr_level;
         end
      end

      assign prio_flat[s*PRIO_W +: PRIO_W]    = prio_q;
      assign depth_flat[s*DEPTH_W +: DEPTH_W] = depth_q;
      assign level_flat[s*LVL_W +: LVL_W]     = level_q;
   end

endmodule

// File: rtl/thr_prio_select.sv
module thr_prio_select #(
   parameter int unsigned NUM_SRC  = 3,
   parameter int unsigned PRIO_W   = 7,
   parameter int unsigned DEPTH_W  = 7,
   parameter int unsigned LVL_W    = 2,
   parameter int unsigned PRIO_MAX = 100,
   parameter int unsigned IDX_W    = 2
) (
   input  logic [NUM_SRC-1:0]           req,
   input  logic [NUM_SRC*PRIO_W-1:0]    prio_flat,
   input  logic [NUM_SRC*DEPTH_W-1:0]   depth_flat,
   input  logic [NUM_SRC*LVL_W-1:0]     level_flat,
   output logic                         sel_valid,
   output logic [IDX_W-1:0]             sel_idx,
   output logic [DEPTH_W-1:0]           sel_depth,
   output logic [LVL_W-1:0]             sel_level
);

   localparam logic [PRIO_W-1:0] PRIO_TOP = PRIO_W'(PRIO_MAX);

   // Linear chain: stage s+1 holds the best candidate among sources 0..s.
   logic [NUM_SRC:0]              c_valid;
   logic [NUM_SRC:0][PRIO_W-1:0]  c_prio;
   logic [NUM_SRC:0][IDX_W-1:0]   c_idx;
   logic [NUM_SRC:0][DEPTH_W-1:0] c_depth;
   logic [NUM_SRC:0][LVL_W-1:0]   c_level;

   assign c_valid[0] = 1'b0;
   assign c_prio[0]  = '0;
   assign c_idx[0]   = '0;
   assign c_depth[0] = '0;
   assign c_level[0] = '0;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_stage
      logic [PRIO_W-1:0] p;
      logic              elig;
      logic              take;

      assign p    = prio_flat[s*PRIO_W +: PRIO_W];
      assign elig = req[s] && (p != '0) && (p <= PRIO_TOP);
      // Strictly greater keeps the earlier (lower-index) source on ties.
      assign take = elig && (!c_valid[s] || (p > c_prio[s]));

      assign c_valid[s+1] = c_valid[s] | elig;
      assign c_prio[s+1]  = take ? p : c_prio[s];
      assign c_idx[s+1]   = take ? IDX_W'(s) : c_idx[s];
      assign c_depth[s+1] = take ? depth_flat[s*DEPTH_W +: DEPTH_W] : c_depth[s];
      assign c_level[s+1] = take ? level_flat[s*LVL_W +: LVL_W] : c_level[s];
   end

   assign sel_valid = c_valid[NUM_SRC];
   assign sel_idx   = c_idx[NUM_SRC];
   assign sel_depth = c_depth[NUM_SRC];
   assign sel_level = c_level[NUM_SRC];

endmodule

// File: rtl/thr_out_reg.sv
module thr_out_reg #(
   parameter int unsigned DEPTH_W = 7,
   parameter int unsigned LVL_W   = 2,
   parameter int unsigned IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sel_valid,
   input  logic [IDX_W-1:0]   sel_idx,
   input  logic [DEPTH_W-1:0] sel_depth,
   input  logic [LVL_W-1:0]   sel_level,
   output logic               o_active,
   output logic [IDX_W-1:0]   o_idx,
   output logic [DEPTH_W-1:0] o_depth,
   output logic [LVL_W-1:0]   o_level
);

   always_ff @(posedge clk) begin
      if (rst || !sel_valid) begin
         o_active <= 1'b0;
         o_idx    <= '0;
         o_depth  <= '0;
         o_level  <= '0;
      end else begin
         o_active <= 1'b1;
         o_idx    <= sel_idx;
         o_depth  <= sel_depth;
         o_level  <= sel_level;
      end
   end

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter #(
   parameter int unsigned NUM_SRC   = 3,
   parameter int unsigned PRIO_W    = 7,
   parameter int unsigned DEPTH_W   = 7,
   parameter int unsigned LVL_W     = 2,
   parameter int unsigned PRIO_MAX  = thr_arb_pkg::DEF_PRIO_MAX,
   parameter int unsigned DEPTH_MAX = thr_arb_pkg::DEF_DEPTH_MAX,
   localparam int unsigned IDX_W    = thr_arb_pkg::idx_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] cfg_we,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic [DEPTH_W-1:0] cfg_depth,
   input  logic [LVL_W-1:0]   cfg_level,
   input  logic [NUM_SRC-1:0] req,
   output logic [DEPTH_W-1:0] thr_cpu_depth,
   output logic [LVL_W-1:0]   thr_gpu_level,
   output logic               thr_active,
   output logic [IDX_W-1:0]   thr_winner
);

   if (NUM_SRC < 1) begin : g_bad_num
      $error("thr_arbiter: NUM_SRC must be at least 1");
   end
   if (PRIO_MAX < 1 || PRIO_MAX >= (1 << PRIO_W)) begin : g_bad_prio
      $error("thr_arbiter: PRIO_MAX must fit in PRIO_W bits and be nonzero");
   end
   if (DEPTH_MAX >= (1 << DEPTH_W)) begin : g_bad_depth
      $error("thr_arbiter: DEPTH_MAX must fit in DEPTH_W bits");
   end

   logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
   logic [NUM_SRC*DEPTH_W-1:0] depth_flat;
   logic [NUM_SRC*LVL_W-1:0]   level_flat;
   logic                       sel_valid;
   logic [IDX_W-1:0]           sel_idx;
   logic [DEPTH_W-1:0]         sel_depth;
   logic [LVL_W-1:0]           sel_level;

   thr_cfg_bank #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W),
      .LVL_W(LVL_W), .DEPTH_MAX(DEPTH_MAX)
   ) u_bank (
      .clk(clk), .rst(rst), .we(cfg_we),
      .wr_prio(cfg_prio), .wr_depth(cfg_depth), .wr_level(cfg_level),
      .prio_flat(prio_flat), .depth_flat(depth_flat), .level_flat(level_flat)
   );

   thr_prio_select #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W),
      .LVL_W(LVL_W), .PRIO_MAX(PRIO_MAX), .IDX_W(IDX_W)
   ) u_sel (
      .req(req), .prio_flat(prio_flat), .depth_flat(depth_flat),
      .level_flat(level_flat), .sel_valid(sel_valid), .sel_idx(sel_idx),
      .sel_depth(sel_depth), .sel_level(sel_level)
   );

   thr_out_reg #(
      .DEPTH_W(DEPTH_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
   ) u_out (
      .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_idx(sel_idx),
      .sel_depth(sel_depth), .sel_level(sel_level),
      .o_active(thr_active), .o_idx(thr_winner),
      .o_depth(thr_cpu_depth), .o_level(thr_gpu_level)
   );

endmodule

// File: rtl/thr_arbiter_chk.sv
module thr_arbiter_chk #(
   parameter int unsigned NUM_SRC   = 3,
   parameter int unsigned DEPTH_W   = 7,
   parameter int unsigned LVL_W     = 2,
   parameter int unsigned DEPTH_MAX = 100,
   parameter int unsigned IDX_W     = 2
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] req,
   input logic [DEPTH_W-1:0] thr_cpu_depth,
   input logic [LVL_W-1:0]   thr_gpu_level,
   input logic               thr_active,
   input logic [IDX_W-1:0]   thr_winner
);

   logic [NUM_SRC-1:0] req_q;

   always_ff @(posedge clk) begin
      if (rst) req_q <= '0;
      else     req_q <= req;
   end

   p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
      !thr_active |-> (thr_cpu_depth == '0 && thr_gpu_level == '0 && thr_winner == '0));

   p_depth_cap_r8: assert property (@(posedge clk) disable iff (rst)
      thr_cpu_depth <= DEPTH_W'(DEPTH_MAX));

   p_no_req_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |=> !thr_active);

   p_winner_requested_r3: assert property (@(posedge clk) disable iff (rst)
      thr_active |-> req_q[thr_winner]);

   p_winner_range_r4: assert property (@(posedge clk) disable iff (rst)
      thr_active |-> (int'(thr_winner) < NUM_SRC));

endmodule

bind thr_arbiter thr_arbiter_chk #(
   .NUM_SRC(NUM_SRC), .DEPTH_W(DEPTH_W), .LVL_W(LVL_W),
   .DEPTH_MAX(DEPTH_MAX), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .req(req), .thr_cpu_depth(thr_cpu_depth),
   .thr_gpu_level(thr_gpu_level), .thr_active(thr_active),
   .thr_winner(thr_winner)
);

// File: tb/test_thr_arbiter.sv
`timescale 1ns/1ps
module test_thr_arbiter;

   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] cfg_we = '0;
   logic [6:0]   cfg_prio = '0;
   logic [6:0]   cfg_depth = '0;
   logic [1:0]   cfg_level = '0;
   logic [N-1:0] req = '0;
   logic [6:0]   thr_cpu_depth;
   logic [1:0]   thr_gpu_level;
   logic         thr_active;
   logic [1:0]   thr_winner;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit running = 0;

   // reference state
   int m_prio[N];
   int m_depth[N];
   int m_level[N];
   int e_depth = 0, e_level = 0, e_active = 0, e_win = 0;

   always #2.5 clk = ~clk;

   thr_arbiter i_thr_arbiter (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_prio(cfg_prio),
      .cfg_depth(cfg_depth), .cfg_level(cfg_level), .req(req),
      .thr_cpu_depth(thr_cpu_depth), .thr_gpu_level(thr_gpu_level),
      .thr_active(thr_active), .thr_winner(thr_winner)
   );

   // Behavioural model: evaluated at each rising edge from the values seen there.
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) begin
            m_prio[i] = 0; m_depth[i] = 0; m_level[i] = 0;
         end
         e_depth = 0; e_level = 0; e_active = 0; e_win = 0;
      end else begin
         int best;
         best = -1;
         for (int i = 0; i < N; i++) begin
            if (req[i] && m_prio[i] >= 1 && m_prio[i] <= 100) begin
               if (best < 0 || m_prio[i] > m_prio[best]) best = i;
            end
         end
         if (best < 0) begin
            e_depth = 0; e_level = 0; e_active = 0; e_win = 0;
         end else begin
            e_depth = m_depth[best]; e_level = m_level[best];
            e_active = 1; e_win = best;
         end
         for (int i = 0; i < N; i++) begin
            if (cfg_we[i]) begin
               m_prio[i]  = int'(cfg_prio);
               m_depth[i] = (cfg_depth > 100) ? 100 : int'(cfg_depth);
               m_level[i] = int'(cfg_level);
            end
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // Compare against the model on every falling edge.
   always @(negedge clk) begin
      cycles++;
      if (running) begin
         check("R4 depth",  int'(thr_cpu_depth), e_depth);
         check("R9 level",  int'(thr_gpu_level), e_level);
         check("R10 active", int'(thr_active),   e_active);
         check("R5 winner", int'(thr_winner),    e_win);
      end
   end

   task automatic wr(input int src, input int p, input int d, input int l);
      @(negedge clk);
      cfg_we = '0; cfg_we[src] = 1'b1;
      cfg_prio = 7'(p); cfg_depth = 7'(d); cfg_level = 2'(l);
      @(negedge clk);
      cfg_we = '0;
   endtask

   task automatic drive_req(input logic [N-1:0] r, input int hold);
      @(negedge clk);
      req = r;
      repeat (hold) @(negedge clk);
   endtask

   // Directed expectation on the outputs just after the next rising edge.
   task automatic expect_out(input string tag, input int d, input int l, input int a, input int w);
      @(negedge clk);
      check({tag, " depth"}, int'(thr_cpu_depth), d);
      check({tag, " level"}, int'(thr_gpu_level), l);
      check({tag, " active"}, int'(thr_active), a);
      check({tag, " winner"}, int'(thr_winner), w);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check("R1 depth", int'(thr_cpu_depth), 0);
      check("R1 active", int'(thr_active), 0);
      running = 1;

      // R3: requests with all priorities 0 keep everything idle (R6)
      drive_req('1, 3);
      check("R3 prio0 idle", int'(thr_active), 0);

      // R2: program light, heavy and overcurrent sources
      wr(0, 80, 50, 1);
      wr(1, 100, 85, 3);
      wr(2, 50, 75, 2);

      // R4: sweep every request pattern
      for (int r = 0; r < 8; r++) drive_req(3'(r), 3);

      // R7: a request change is not visible before the next edge
      drive_req(3'b001, 2);
      @(negedge clk);
      req = 3'b010;
      #1;
      check("R7 latency hold", int'(thr_winner), 0);
      expect_out("R7", 85, 3, 1, 1);

      // R5: tie between sources 1 and 2 at priority 100
      wr(2, 100, 75, 2);
      drive_req(3'b110, 2);
      check("R5 tie low index", int'(thr_winner), 1);
      drive_req(3'b100, 2);
      check("R5 sole source", int'(thr_winner), 2);

      // R3: priority 101 removes source 1
      wr(1, 101, 85, 3);
      drive_req(3'b011, 2);
      check("R3 prio101 excluded", int'(thr_winner), 0);

      // R8: oversized depth saturates
      wr(0, 90, 120, 0);
      drive_req(3'b001, 2);
      check("R8 depth cap", int'(thr_cpu_depth), 100);

      // R2: a write to source 2 leaves source 0 unchanged
      wr(2, 10, 5, 1);
      drive_req(3'b001, 2);
      check("R2 other unchanged", int'(thr_cpu_depth), 100);

      // R6: nothing requested
      drive_req('0, 2);
      check("R6 idle active", int'(thr_active), 0);

      // Random phase covering all rules
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         req = N'($urandom);
         if (($urandom % 4) == 0) begin
            cfg_we = N'($urandom);
            cfg_prio = 7'($urandom);
            cfg_depth = 7'($urandom);
            cfg_level = 2'($urandom);
         end else begin
            cfg_we = '0;
         end
      end
      @(negedge clk);
      cfg_we = '0;
      repeat (3) @(negedge clk);

      // R1: reset mid-run clears sources and outputs
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      req = '1;
      repeat (2) @(negedge clk);
      check("R1 reset clears config", int'(thr_active), 0);

      running = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule